// File: doc/BRIEF.md
# Reciprocal-Multiply Binary-to-BCD Converter

This block turns one unsigned binary number between 0 and 999,999,999 into nine packed BCD digits without any divider. The input is first scaled by a rounded-up constant close to 2^60 / 10^9. That multiply turns the integer into a binary fraction of the decimal range, with 28 guard bits beyond a 32-bit fraction. Repeated multiplies by 10 and then by 100 lift the digits above the binary point. The leading digit comes out first, then four digit pairs from high to low. After each multiply the whole part is taken as the digits and the fractional part is kept for the next step. A 100-entry table turns each whole part (0..99) into two BCD nibbles.

All six multiplies share one pipelined multiplier whose latency is a parameter. The input side is a valid/ready handshake that takes a 30-bit binary value. The output side is a single-cycle valid pulse with a 36-bit BCD word, which stays on the port until the next result.

Top module: `bcd_recip_conv`

## Requirements
- R1: While `rst_ni` is low and just after it is released, `in_ready_o` is 1, `out_valid_o` is 0 and `out_bcd_o` is zero. A reset in the middle of a conversion abandons it with no valid pulse.
- R2: An input is taken only on a rising clock edge where `in_valid_i` and `in_ready_o` are both 1. Values offered while the block is busy are ignored and do not change the result.
- R3: `in_ready_o` is 0 in every cycle from the accepting edge until the output pulse. It is 1 again in the pulse cycle.
- R4: `out_valid_o` is high for exactly one cycle. It rises at the 6*(MUL_LAT+1)-th rising edge after the accepting edge, which is 24 edges with the default MUL_LAT of 3.
- R5: `out_bcd_o` holds nine 4-bit decimal digits. The most significant digit is in bits 35:32 and the least significant in bits 3:0. Leading zeros are kept, so 42 gives 36'h000000042.
- R6: The conversion is exact for every input from 0 to 999,999,999. This includes 0, 9, 10, 99, 100, every 10^k and every 10^k-1.
- R7: Every nibble of `out_bcd_o` in a pulse cycle is in the range 0..9.
- R8: `out_bcd_o` keeps its last value in every cycle without a pulse.
- R9: A new input can be accepted in the pulse cycle itself, so conversions can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input value offered |
| in_ready_o | output | 1 | Converter idle, input accepted on this edge if valid |
| in_bin_i | input | 30 | Unsigned binary value, 0..999,999,999 |
| out_valid_o | output | 1 | One-cycle pulse, result on out_bcd_o |
| out_bcd_o | output | 36 | Nine packed BCD digits, most significant in 35:32 |

## Verification
Each result is due a fixed number of edges after the accepting edge: 6*(MUL_LAT+1), which is 24 by default. The bench counts rising edges from acceptance and samples on falling edges. It expects the pulse at exactly that count, with ready low before it and high in it, and it compares the data only in that cycle. On the falling edge after the pulse it checks that valid has dropped and the data is still held. For back-to-back operation it expects the second pulse 6*(MUL_LAT+1)+1 edges after the first. An independent divide/modulo model gives the expected digits for the pseudo-random values.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned IN_W    = 30;
  localparam int unsigned DIGITS  = 9;
  localparam int unsigned OUT_W   = 4 * DIGITS;
  localparam int unsigned INT_W   = 7;             // whole part of frac*100 fits 0..99
  localparam int unsigned B_W     = 31;            // widest second operand (prescale)
  localparam int unsigned PAIRS   = (DIGITS - 1) / 2;
  localparam int unsigned NUM_OPS = 2 + PAIRS;     // prescale, lead digit, pairs
  localparam int unsigned OP_W    = $clog2(NUM_OPS);

  function automatic logic [63:0] pow10(input int unsigned n);
    logic [63:0] r;
    r = 64'd1;
    for (int k = 0; k < n; k++) r = r * 64'd10;
    return r;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } brc_state_e;
endpackage

// File: rtl/brc_mul_pipe.sv
module brc_mul_pipe #(
  parameter int unsigned A_W = 60,
  parameter int unsigned B_W = 31,
  parameter int unsigned P_W = 67,
  parameter int unsigned LAT = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           issue_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           res_valid_o,
  output logic [P_W-1:0] res_o
);
  logic [P_W-1:0] prod_q  [LAT];
  logic [LAT-1:0] valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int k = 0; k < LAT; k++) prod_q[k] <= '0;
    end else begin
      valid_q[0] <= issue_i;
      if (issue_i) prod_q[0] <= P_W'(a_i) * P_W'(b_i);
      for (int k = 1; k < LAT; k++) begin
        valid_q[k] <= valid_q[k-1];
        prod_q[k]  <= prod_q[k-1];
      end
    end
  end

  assign res_valid_o = valid_q[LAT-1];
  assign res_o       = prod_q[LAT-1];
endmodule

// File: rtl/brc_pair_lut.sv
module brc_pair_lut #(
  parameter int unsigned IDX_W = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       bcd_o
);
  localparam int unsigned ENTRIES = 100;
  logic [7:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign tbl[i] = {4'(i / 10), 4'(i % 10)};
  end

  always_comb begin
    bcd_o = '0;
    if (int'(idx_i) < ENTRIES) bcd_o = tbl[idx_i];
  end
endmodule

// File: rtl/brc_ctrl.sv
module brc_ctrl
  import brc_pkg::*;
#(
  parameter int unsigned FRAC_W = 60,
  parameter logic [B_W-1:0] SCALE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IN_W-1:0]   in_bin_i,
  output logic              issue_o,
  output logic [FRAC_W-1:0] mul_a_o,
  output logic [B_W-1:0]    mul_b_o,
  input  logic              res_valid_i,
  input  logic [FRAC_W-1:0] res_frac_i,
  input  logic [7:0]        pair_bcd_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_bcd_o
);
  localparam logic [OP_W-1:0] LAST_OP = OP_W'(NUM_OPS - 1);

  brc_state_e        state_q;
  logic [OP_W-1:0]   op_q;
  logic [IN_W-1:0]   bin_q;
  logic [FRAC_W-1:0] frac_q;
  logic [OUT_W-1:0]  acc_q, out_q;
  logic              out_valid_q;
  logic              accept;

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign issue_o    = (state_q == ST_ISSUE);

  always_comb begin
    if (op_q == '0) begin
      mul_a_o = FRAC_W'(bin_q);
      mul_b_o = SCALE;
    end else begin
      mul_a_o = frac_q;
      mul_b_o = (op_q == OP_W'(1)) ? B_W'(10) : B_W'(100);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= '0;
      bin_q       <= '0;
      frac_q      <= '0;
      acc_q       <= '0;
      out_q       <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            bin_q   <= in_bin_i;
            op_q    <= '0;
            acc_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (res_valid_i) begin
            frac_q <= res_frac_i;
            // prescale result carries no digits
            if (op_q != '0) acc_q <= {acc_q[OUT_W-9:0], pair_bcd_i};
            if (op_q == LAST_OP) begin
              out_q       <= {acc_q[OUT_W-9:0], pair_bcd_i};
              out_valid_q <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              op_q    <= op_q + OP_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_bcd_o   = out_q;
endmodule

// File: rtl/bcd_recip_conv.sv
module bcd_recip_conv
  import brc_pkg::*;
#(
  parameter int unsigned MUL_LAT = 3,
  parameter int unsigned FRAC_W  = 60   // >= 60 keeps every digit exact
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IN_W-1:0]  in_bin_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_bcd_o
);
  localparam int unsigned P_W = FRAC_W + INT_W;
  localparam logic [63:0] RANGE = pow10(DIGITS);
  // round-up reciprocal: error stays positive and below one final unit
  localparam logic [63:0] SCALE_FULL = ((64'd1 << FRAC_W) + RANGE - 64'd1) / RANGE;
  localparam logic [B_W-1:0] SCALE = B_W'(SCALE_FULL);

  logic              issue;
  logic [FRAC_W-1:0] mul_a;
  logic [B_W-1:0]    mul_b;
  logic              res_valid;
  logic [P_W-1:0]    res;
  logic [7:0]        pair_bcd;

  brc_ctrl #(
    .FRAC_W(FRAC_W),
    .SCALE (SCALE)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_bin_i   (in_bin_i),
    .issue_o    (issue),
    .mul_a_o    (mul_a),
    .mul_b_o    (mul_b),
    .res_valid_i(res_valid),
    .res_frac_i (res[FRAC_W-1:0]),
    .pair_bcd_i (pair_bcd),
    .out_valid_o(out_valid_o),
    .out_bcd_o  (out_bcd_o)
  );

  brc_mul_pipe #(
    .A_W(FRAC_W),
    .B_W(B_W),
    .P_W(P_W),
    .LAT(MUL_LAT)
  ) i_mul (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .a_i        (mul_a),
    .b_i        (mul_b),
    .res_valid_o(res_valid),
    .res_o      (res)
  );

  brc_pair_lut #(
    .IDX_W(INT_W)
  ) i_lut (
    .idx_i(res[P_W-1:FRAC_W]),
    .bcd_o(pair_bcd)
  );
endmodule

// File: rtl/bcd_recip_conv_chk.sv
module bcd_recip_conv_chk
  import brc_pkg::*;
#(
  parameter int unsigned MUL_LAT = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] out_bcd_o
);
  localparam int unsigned LATENCY = NUM_OPS * (MUL_LAT + 1);

  logic        busy_q;
  logic [15:0] cnt_q;
  logic        accept;

  assign accept = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (out_valid_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 16'd1;
    end
  end

  function automatic logic digits_ok(input logic [OUT_W-1:0] x);
    for (int k = 0; k < DIGITS; k++) if (x[4*k+:4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  assert_ready_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !in_ready_o);
  assert_ready_in_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> in_ready_o);
  assert_busy_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !out_valid_o) |-> !in_ready_o);
  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (busy_q && cnt_q == 16'(LATENCY)));
  assert_digit_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> digits_ok(out_bcd_o));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_bcd_o));
endmodule

bind bcd_recip_conv bcd_recip_conv_chk #(.MUL_LAT(MUL_LAT)) i_bcd_recip_conv_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_bcd_o  (out_bcd_o)
);

// File: tb/test_bcd_recip_conv.sv
module test_bcd_recip_conv;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned MUL_LAT = 3;
  localparam int LAT_EDGES = 6 * (MUL_LAT + 1);
  localparam int NVEC = 22;

  localparam logic [29:0] VEC_IN [NVEC] = '{
    30'd0, 30'd9, 30'd10, 30'd99, 30'd100, 30'd999, 30'd1000, 30'd9999,
    30'd10000, 30'd99999, 30'd100000, 30'd999999, 30'd1000000, 30'd9999999,
    30'd10000000, 30'd99999999, 30'd100000000, 30'd999999999, 30'd123456789,
    30'd42, 30'd987654321, 30'd500000001
  };
  localparam logic [35:0] VEC_EXP [NVEC] = '{
    36'h0, 36'h9, 36'h10, 36'h99, 36'h100, 36'h999, 36'h1000, 36'h9999,
    36'h10000, 36'h99999, 36'h100000, 36'h999999, 36'h1000000, 36'h9999999,
    36'h10000000, 36'h99999999, 36'h100000000, 36'h999999999, 36'h123456789,
    36'h000000042, 36'h987654321, 36'h500000001
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [29:0] in_bin = '0;
  logic        in_ready;
  logic        out_valid;
  logic [35:0] out_bcd;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_recip_conv #(.MUL_LAT(MUL_LAT)) i_bcd_recip_conv (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .in_bin_i   (in_bin),
    .out_valid_o(out_valid),
    .out_bcd_o  (out_bcd)
  );

  function automatic logic [35:0] ref_bcd(input logic [29:0] v);
    logic [35:0] r;
    int unsigned x;
    r = '0;
    x = v;
    for (int k = 0; k < 9; k++) begin
      r[4*k+:4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offer v, wait for acceptance; returns at the falling edge after the accepting edge
  task automatic offer(input logic [29:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_bin   = v;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // count edges until pulse; checks ready low meanwhile (R3)
  task automatic wait_pulse(output int lat);
    logic ready_bad;
    ready_bad = 1'b0;
    lat = 0;
    while (!out_valid && lat < 200) begin
      if (in_ready) ready_bad = 1'b1;
      @(negedge clk);
      lat++;
    end
    check(!ready_bad, "R3 ready low while busy", 64'(ready_bad), 64'd0);
    check(in_ready, "R3 ready high in pulse", 64'(in_ready), 64'd1);
  endtask

  task automatic run_conv(input logic [29:0] v, input logic [35:0] exp, input string req);
    int lat;
    logic [35:0] got;
    offer(v);
    wait_pulse(lat);
    check(lat == LAT_EDGES, "R4 latency", 64'(lat), 64'(LAT_EDGES));
    got = out_bcd;
    check(got == exp, req, 64'(got), 64'(exp));
    @(negedge clk);
    check(!out_valid, "R4 single pulse", 64'(out_valid), 64'd0);
    check(out_bcd == got, "R8 data held", 64'(out_bcd), 64'(got));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    int lat;
    // R1 reset state
    #(CLK_PERIOD * 3);
    check(in_ready == 1'b1, "R1 ready in reset", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'd0);
    check(out_bcd == '0, "R1 data in reset", 64'(out_bcd), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid && out_bcd == '0, "R1 after release",
          64'({in_ready, out_valid}), 64'h2);

    // table: R5 packing and R6 exactness at range ends and powers of ten
    for (int i = 0; i < NVEC; i++) run_conv(VEC_IN[i], VEC_EXP[i], "R6 R5 table value");

    // pseudo-random values against divide/modulo model (R6, R7 via digits)
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 40; i++) begin
      logic [29:0] v;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      v = 30'(lfsr % 32'd1000000000);
      run_conv(v, ref_bcd(v), "R6 R7 random value");
    end

    // R2: input offered while busy is ignored
    offer(30'd123456789);
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    in_bin   = 30'd999;
    repeat (8) @(negedge clk);
    in_valid = 1'b0;
    wait_pulse(lat);
    check(out_bcd == 36'h123456789, "R2 busy input ignored", 64'(out_bcd), 64'h123456789);
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (out_valid) lat++;
    end
    check(lat == 0, "R2 no extra pulse", 64'(lat), 64'd0);
    check(out_bcd == 36'h123456789, "R8 held while idle", 64'(out_bcd), 64'h123456789);

    // R9: back to back, second value taken in the pulse cycle
    offer(30'd314159265);
    in_valid = 1'b1;
    in_bin   = 30'd271828182;
    wait_pulse(lat);
    check(out_bcd == 36'h314159265, "R9 first result", 64'(out_bcd), 64'h314159265);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R9 second accepted in pulse cycle", 64'(in_ready), 64'd0);
    wait_pulse(lat);
    check(lat + 1 == LAT_EDGES + 1, "R9 second pulse spacing", 64'(lat + 1),
          64'(LAT_EDGES + 1));
    check(out_bcd == 36'h271828182, "R9 second result", 64'(out_bcd), 64'h271828182);

    // R1: reset mid-conversion abandons it
    offer(30'd777777777);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(in_ready && out_bcd == '0, "R1 reset mid-run", 64'(out_bcd), 64'd0);
    rst_n = 1'b1;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (out_valid) lat++;
    end
    check(lat == 0, "R1 no pulse after abort", 64'(lat), 64'd0);

    run_conv(30'd999999999, 36'h999999999, "R6 top after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule